// File: doc/BRIEF.md
# Coded-Ratio Reference Divider

This block turns a reference timebase into the comparison clock that feeds a PLL phase/frequency detector. The reference arrives as a single-cycle enable (`refEn`) in the system clock domain, nominally one per cycle of an 8 MHz crystal oscillator. A 4-bit rate code selects one of fifteen preset ratios. Codes with the top bit clear give the powers of two from 2 to 256. Codes with the top bit set give five times a power of two, from 5 to 320. The one code left over is reserved.

The divider produces a clock-like output (`divClk`) and a one-cycle marker (`cmpTick`) at each of its rising edges. A new code is sampled only at the boundary between two output periods, so a ratio change never produces a runt pulse. When the reserved code is sampled, the block raises `codeBad`, parks the output low and waits. It restarts on the first reference enable that finds a valid code again.

Top module: `refdiv_top`

## Requirements
- R1: While `rstN` is low, and after its release until the first `refEn` pulse, `divClk`, `cmpTick` and `codeBad` are all 0.
- R2: A code `c` from 0 to 7 (`rateCode[3]`=0) gives an output period of 2^(c+1) `refEn` pulses, that is 2, 4, 8 … 256.
- R3: A code `c` from 9 to 15 gives an output period of 5·2^(c−9) `refEn` pulses, that is 5, 10, 20 … 320.
- R4: Code 8 (binary 1000) is reserved. Once it is sampled at a period boundary, `codeBad` goes to 1, `divClk` stays 0 and no `cmpTick` occurs. While the block is parked, every `refEn` pulse resamples the code. The first pulse that finds a valid code clears `codeBad` and starts a new high phase.
- R5: For an even ratio N, `divClk` is high for N/2 `refEn` pulses and low for N/2.
- R6: For an odd ratio N, `divClk` is high for (N+1)/2 `refEn` pulses and low for (N−1)/2, so the high phase is one pulse longer.
- R7: A change of `rateCode` in the middle of a period has no effect on that period. The new ratio applies from the next period boundary.
- R8: `cmpTick` is a single-cycle pulse, present exactly in the cycle in which `divClk` rises. The outputs change only in the cycle after a `refEn` pulse.
- R9: The first `refEn` pulse after reset samples the code and, if it is valid, makes `divClk` and `cmpTick` go high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refEn | input | 1 | One-cycle pulse per reference period |
| rateCode | input | 4 | Ratio select code |
| divClk | output | 1 | Divided comparison clock |
| cmpTick | output | 1 | One-cycle pulse on each rising edge of `divClk` |
| codeBad | output | 1 | Reserved code is active; output is parked |

## Verification
Every power-of-two code and every five-based code is measured over a full period. The measurement counts both the period length and the high-phase length, which separates a wrong code-to-ratio decode from a wrong duty split. The ratio of 5 is the only odd ratio in the set, so it decides the odd-duty rule on its own. A code change made two pulses into a period shows whether the divider waits for the boundary or reloads at once. The reserved code is entered and then left, which checks both the parked state and the way the divider restarts. A long stretch with no reference enable shows that nothing moves without a `refEn` pulse.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  // largest preset ratio and the counter width it implies
  localparam int MAX_RATIO = 320;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);
  localparam int CODE_W    = 4;
  localparam logic [CODE_W-1:0] CODE_RESERVED = 4'b1000;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;   // start a new period with ratio below
    logic             step;   // advance one reference pulse
    logic             stop;   // park output low
    logic [CNT_W-1:0] ratio;  // ratio to load
  } div_cmd_t;

  // code to ratio: top bit clear -> 2<<k, top bit set -> 5<<(k-1)
  function automatic logic [CNT_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    if (!code[CODE_W-1]) r = CNT_W'(2) << code[CODE_W-2:0];
    else                 r = CNT_W'(5) << (code[CODE_W-2:0] - 3'd1);
    return r;
  endfunction
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int CW = CODE_W
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          refEn,
  input  logic [CW-1:0] rateCode,
  input  logic          atEnd,
  output div_cmd_t      cmd,
  output logic          codeBad
);
  logic runQ;
  logic badQ;
  logic codeOk;
  logic reloadPt;

  // a period boundary, or every pulse while idle/parked
  assign codeOk   = (rateCode != CODE_RESERVED);
  assign reloadPt = refEn && (!runQ || atEnd);

  always_comb begin
    cmd.load  = reloadPt && codeOk;
    cmd.stop  = reloadPt && !codeOk;
    cmd.step  = refEn && !reloadPt;
    cmd.ratio = ratioOf(rateCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      badQ <= 1'b0;
    end else if (reloadPt) begin
      runQ <= codeOk;
      badQ <= !codeOk;
    end
  end

  assign codeBad = badQ;
endmodule

// File: rtl/refdiv_path.sv
module refdiv_path
  import refdiv_pkg::*;
#(
  parameter int W = CNT_W
)(
  input  logic     clk,
  input  logic     rstN,
  input  div_cmd_t cmd,
  output logic     atEnd,
  output logic     divClk,
  output logic     cmpTick
);
  logic [W-1:0] cntQ;
  logic [W-1:0] ratioQ;
  logic [W-1:0] hiLenQ;
  logic [W-1:0] cntNext;
  logic [W-1:0] hiLenD;
  logic         divQ;
  logic         tickQ;

  assign cntNext = cntQ + W'(1);
  // high phase takes the larger half of an odd ratio
  assign hiLenD  = W'((cmd.ratio + W'(1)) >> 1);
  assign atEnd   = (cntQ == ratioQ - W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      ratioQ <= W'(2);
      hiLenQ <= W'(1);
      divQ   <= 1'b0;
      tickQ  <= 1'b0;
    end else if (cmd.load) begin
      cntQ   <= '0;
      ratioQ <= cmd.ratio;
      hiLenQ <= hiLenD;
      divQ   <= 1'b1;
      tickQ  <= 1'b1;
    end else if (cmd.step) begin
      cntQ   <= cntNext;
      divQ   <= (cntNext < hiLenQ);
      tickQ  <= 1'b0;
    end else if (cmd.stop) begin
      cntQ   <= '0;
      divQ   <= 1'b0;
      tickQ  <= 1'b0;
    end else begin
      tickQ  <= 1'b0;
    end
  end

  assign divClk  = divQ;
  assign cmpTick = tickQ;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int W  = CNT_W
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          refEn,
  input  logic [CW-1:0] rateCode,
  output logic          divClk,
  output logic          cmpTick,
  output logic          codeBad
);
  div_cmd_t cmd;
  logic     atEnd;

  refdiv_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .refEn(refEn), .rateCode(rateCode),
    .atEnd(atEnd), .cmd(cmd), .codeBad(codeBad)
  );

  refdiv_path #(.W(W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .atEnd(atEnd), .divClk(divClk), .cmpTick(cmpTick)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk (
  input logic clk,
  input logic rstN,
  input logic refEn,
  input logic divClk,
  input logic cmpTick,
  input logic codeBad
);
  // parked output stays low with no ticks (R4)
  p_bad_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    codeBad |-> (!divClk && !cmpTick));

  // tick coincides with the rising edge (R8)
  p_tick_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divClk) |-> cmpTick);

  p_tick_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmpTick |-> divClk);

  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmpTick |=> !cmpTick);

  // nothing moves without a reference pulse (R8, R7)
  p_en_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !refEn |=> ($stable(divClk) && $stable(codeBad) && !cmpTick));
endmodule

bind refdiv_top refdiv_chk u_chk (
  .clk(clk), .rstN(rstN), .refEn(refEn),
  .divClk(divClk), .cmpTick(cmpTick), .codeBad(codeBad)
);

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refEn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       divClk, cmpTick, codeBad;
  logic       d, t, b;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  refdiv_top u0 (
    .clk(clk), .rstN(rstN), .refEn(refEn), .rateCode(rateCode),
    .divClk(divClk), .cmpTick(cmpTick), .codeBad(codeBad)
  );

  function automatic int expRatio(input int c);
    if (c < 8) return 2 << c;
    return 5 << (c - 9);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one reference pulse, then sample outputs a cycle later
  task automatic stepEn();
    @(negedge clk) refEn = 1'b1;
    @(negedge clk) refEn = 1'b0;
    d = divClk; t = cmpTick; b = codeBad;
  endtask

  task automatic syncTick(input string req);
    int n = 0;
    do begin stepEn(); n++; end while (!t && n < 800);
    chk(t, req, t, 1);
  endtask

  task automatic measure(input int code, input string req);
    int hi, tot;
    int r = expRatio(code);
    rateCode = 4'(code);
    syncTick(req);
    hi = 1; tot = 1;
    for (int k = 0; k < 400; k++) begin
      stepEn();
      if (t) break;
      tot++;
      if (d) hi++;
    end
    chk(tot == r, req, tot, r);
    chk(hi == (r + 1) / 2, (r % 2) ? "R6 odd duty" : "R5 even duty", hi, (r + 1) / 2);
  endtask

  task automatic t_reset();
    rstN = 1'b0; refEn = 1'b0; rateCode = 4'd0;
    repeat (3) @(negedge clk);
    chk(!divClk && !cmpTick && !codeBad, "R1 in reset", divClk, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!divClk && !cmpTick && !codeBad, "R1 after release", divClk, 0);
  endtask

  task automatic t_first();
    stepEn();
    chk(d && t && !b, "R9 first pulse starts high", {d, t}, 3);
  endtask

  task automatic t_pow2();
    for (int c = 0; c < 8; c++) measure(c, "R2 power-of-two period");
  endtask

  task automatic t_five();
    for (int c = 9; c < 16; c++) measure(c, "R3 five-based period");
  endtask

  task automatic t_midchange();
    int tot;
    rateCode = 4'd2;
    syncTick("R7 sync");
    tot = 1;
    stepEn(); stepEn(); tot += 2;
    rateCode = 4'd0;
    for (int k = 0; k < 50; k++) begin
      stepEn();
      if (t) break;
      tot++;
    end
    chk(tot == 8, "R7 old period kept", tot, 8);
    tot = 1;
    for (int k = 0; k < 50; k++) begin
      stepEn();
      if (t) break;
      tot++;
    end
    chk(tot == 2, "R7 new ratio after boundary", tot, 2);
  endtask

  task automatic t_noen();
    logic d0;
    syncTick("R8 sync");
    @(negedge clk);
    chk(!cmpTick, "R8 tick one cycle", cmpTick, 0);
    d0 = divClk;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(divClk == d0 && !cmpTick, "R8 hold without refEn", divClk, d0);
    end
  endtask

  task automatic t_invalid();
    int n = 0;
    rateCode = 4'd8;
    do begin stepEn(); n++; end while (!b && n < 800);
    chk(b && !d, "R4 reserved parks low", {b, d}, 2);
    for (int k = 0; k < 10; k++) begin
      stepEn();
      chk(b && !d && !t, "R4 stays parked", {b, d, t}, 4);
    end
    rateCode = 4'd9;
    stepEn();
    chk(d && t && !b, "R4 restart on valid code", {d, t, b}, 6);
    begin
      int hi = 1, tot = 1;
      for (int k = 0; k < 50; k++) begin
        stepEn();
        if (t) break;
        tot++;
        if (d) hi++;
      end
      chk(tot == 5, "R4 R3 ratio after restart", tot, 5);
      chk(hi == 3, "R6 odd high phase", hi, 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first();
    t_pow2();
    t_five();
    t_midchange();
    t_noen();
    t_invalid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule